// File: doc/BRIEF.md
# Protected Simple Dual-Port RAM

A word-addressed memory with a write-only port and a read-only port sharing one clock. Each stored word can carry an extended Hamming SECDED code (single-bit errors corrected, double-bit errors detected) or one even-parity bit per byte. It can also be built with no protection at all. The storage is a behavioural register array inside the block. When neither protection parameter is set, the write mask is honoured bit by bit.

Optional registers sit ahead of the array and behind the decoder, so read latency can be traded against timing. Every read returns the data, a one-cycle valid strobe and a two-bit error status. Bit 1 of that status means an uncorrectable error. Bit 0 means a single-bit error that has been corrected. SECDED takes effect only for widths of 32 or 64 bits. Parity takes effect only when SECDED is not active and the width is a multiple of 8.

Top module: `prot_sdp_ram`

## Requirements
- R1: A read request is answered by `rd_valid_o` high for exactly one cycle, 1 + EnableInReg + EnableOutReg cycles after the request edge. `rd_valid_o` is low in every cycle that does not answer a request.
- R2: A read returns the last content written to that address. Without protection, only bits whose mask bit is 1 are written. With parity, only byte lanes whose mask byte is 0xFF are written. With SECDED, the whole word is written.
- R3: A read and a write to the same address on the same edge return the content from before that write.
- R4: With SECDED, a single flipped data bit in a stored word is corrected in `rd_data_o`, and `rd_err_o` reads 2'b01.
- R5: With SECDED, two flipped data bits in a stored word give `rd_err_o` = 2'b10.
- R6: With parity, a byte holding an odd number of flipped bits gives `rd_err_o` = 2'b10, and the data is returned as stored, without correction.
- R7: `rd_err_o` is 2'b00 on every read of an uncorrupted word and in every cycle where `rd_valid_o` is low.
- R8: While `rst_ni` is low, `rd_valid_o` and `rd_err_o` are 0.
- R9: With SECDED, every accepted write must carry an all-ones mask. With parity, every mask byte must be 0x00 or 0xFF. Writes that follow these rules store and read back correctly.
- R10: A write over a corrupted word clears the error for the bits it rewrites. With SECDED this is the whole word; with parity it is each written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_req_i | input | 1 | Write request |
| wr_addr_i | input | AddrW | Write address |
| wr_data_i | input | Width | Write data |
| wr_mask_i | input | Width | Bit-granular write mask, 1 = write |
| rd_req_i | input | 1 | Read request |
| rd_addr_i | input | AddrW | Read address |
| rd_data_o | output | Width | Read data, corrected under SECDED |
| rd_valid_o | output | 1 | Read data and error status valid |
| rd_err_o | output | 2 | Bit 1 uncorrectable, bit 0 corrected |

## Verification
The error paths are the hardest to reach, because no port can place a corrupted word in the array: every write goes through the encoder. The bench waits until the pipeline is idle, then flips chosen data bits directly in the storage array. It then issues a read. It records the flip pattern per address, and from that pattern predicts the corrected data and the status. A later full-word or byte-masked write then shows that the rewritten bits are clean again. Four configurations run side by side: 32-bit SECDED with both registers, 64-bit SECDED with only the input register, parity without registers, and no protection with only the output register.

// File: rtl/prot_ram_pkg.sv
package prot_ram_pkg;

  // Hamming bits r with 2**r >= w + r + 1
  function automatic int ecc_hamming_bits(int w);
    int r;
    r = 1;
    while ((1 << r) < w + r + 1) r++;
    return r;
  endfunction

  // Codeword position of data bit idx (skips powers of two)
  function automatic int ecc_data_pos(int idx);
    int cnt;
    int pos;
    cnt = 0;
    pos = 0;
    for (int p = 1; p < 256; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == idx && pos == 0) pos = p;
        cnt++;
      end
    end
    return pos;
  endfunction

  // Data bits covered by Hamming bit j
  function automatic logic [63:0] ecc_col_mask(int j);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < 64; i++) m[i] = 1'(ecc_data_pos(i) >> j);
    return m;
  endfunction

  function automatic int check_bits(int w, bit ecc, bit par);
    if (ecc) return ecc_hamming_bits(w) + 1;
    if (par) return w / 8;
    return 1;
  endfunction

endpackage

// File: rtl/prot_ram_enc.sv
module prot_ram_enc import prot_ram_pkg::*; #(
  parameter int Width = 32,
  parameter bit EccOn = 1'b1,
  parameter bit ParOn = 1'b0,
  localparam int CheckW = check_bits(Width, EccOn, ParOn)
) (
  input  logic [Width-1:0]  data_i,
  output logic [CheckW-1:0] check_o
);

  if (EccOn) begin : g_ecc
    localparam int R = ecc_hamming_bits(Width);
    logic [R-1:0] ham;
    for (genvar j = 0; j < R; j++) begin : g_col
      localparam logic [63:0] ColM = ecc_col_mask(j);
      assign ham[j] = ^(data_i & ColM[Width-1:0]);
    end
    // overall bit makes the whole stored word even
    assign check_o = {^{ham, data_i}, ham};
  end else if (ParOn) begin : g_par
    for (genvar b = 0; b < CheckW; b++) begin : g_byte
      assign check_o[b] = ^data_i[8*b +: 8];
    end
  end else begin : g_none
    logic unused_data;
    assign unused_data = ^data_i;
    assign check_o = '0;
  end

endmodule

// File: rtl/prot_ram_dec.sv
module prot_ram_dec import prot_ram_pkg::*; #(
  parameter int Width = 32,
  parameter bit EccOn = 1'b1,
  parameter bit ParOn = 1'b0,
  localparam int CheckW = check_bits(Width, EccOn, ParOn)
) (
  input  logic [Width-1:0]  data_i,
  input  logic [CheckW-1:0] check_i,
  output logic [Width-1:0]  data_o,
  output logic [1:0]        err_o
);

  if (EccOn) begin : g_ecc
    localparam int R = ecc_hamming_bits(Width);
    logic [R-1:0] syn;
    logic         ovr;
    for (genvar j = 0; j < R; j++) begin : g_col
      localparam logic [63:0] ColM = ecc_col_mask(j);
      assign syn[j] = check_i[j] ^ (^(data_i & ColM[Width-1:0]));
    end
    assign ovr = ^{check_i, data_i};
    for (genvar i = 0; i < Width; i++) begin : g_fix
      localparam int Pos = ecc_data_pos(i);
      assign data_o[i] = data_i[i] ^ (ovr && (syn == R'(Pos)));
    end
    // odd overall parity: single error; even with nonzero syndrome: double
    assign err_o = {~ovr & (|syn), ovr};
  end else if (ParOn) begin : g_par
    logic [CheckW-1:0] bad;
    for (genvar b = 0; b < CheckW; b++) begin : g_byte
      assign bad[b] = check_i[b] ^ (^data_i[8*b +: 8]);
    end
    assign data_o = data_i;
    assign err_o  = {|bad, 1'b0};
  end else begin : g_none
    logic unused_check;
    assign unused_check = ^check_i;
    assign data_o = data_i;
    assign err_o  = 2'b00;
  end

endmodule

// File: rtl/prot_ram_array.sv
module prot_ram_array #(
  parameter int Depth  = 512,
  parameter int StoreW = 39,
  localparam int AddrW = $clog2(Depth)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AddrW-1:0]  waddr_i,
  input  logic [StoreW-1:0] wdata_i,
  input  logic [StoreW-1:0] wmask_i,
  input  logic              re_i,
  input  logic [AddrW-1:0]  raddr_i,
  output logic [StoreW-1:0] rdata_o
);

  logic [StoreW-1:0] mem_q [Depth];
  logic [StoreW-1:0] rdata_q;

  // nonblocking read sees the pre-write word on a collision
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= (mem_q[waddr_i] & ~wmask_i) | (wdata_i & wmask_i);
    if (re_i) rdata_q <= mem_q[raddr_i];
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/prot_sdp_ram.sv
module prot_sdp_ram import prot_ram_pkg::*; #(
  parameter int Depth        = 512,
  parameter int Width        = 32,
  parameter bit EnableEcc    = 1'b1,
  parameter bit EnableParity = 1'b0,
  parameter bit EnableInReg  = 1'b0,
  parameter bit EnableOutReg = 1'b0,
  localparam int AddrW = $clog2(Depth)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_req_i,
  input  logic [AddrW-1:0] wr_addr_i,
  input  logic [Width-1:0] wr_data_i,
  input  logic [Width-1:0] wr_mask_i,
  input  logic             rd_req_i,
  input  logic [AddrW-1:0] rd_addr_i,
  output logic [Width-1:0] rd_data_o,
  output logic             rd_valid_o,
  output logic [1:0]       rd_err_o
);

  localparam bit EccOn  = EnableEcc && (Width == 32 || Width == 64);
  localparam bit ParOn  = !EccOn && EnableParity && (Width % 8 == 0);
  localparam int CheckW = check_bits(Width, EccOn, ParOn);
  localparam int StoreW = Width + CheckW;
  localparam int Lat    = 1 + int'(EnableInReg) + int'(EnableOutReg);

  logic             wr_req_s, rd_req_s;
  logic [AddrW-1:0] wr_addr_s, rd_addr_s;
  logic [Width-1:0] wr_data_s, wr_mask_s;

  if (EnableInReg) begin : g_in_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wr_req_s  <= 1'b0;
        rd_req_s  <= 1'b0;
        wr_addr_s <= '0;
        rd_addr_s <= '0;
        wr_data_s <= '0;
        wr_mask_s <= '0;
      end else begin
        wr_req_s  <= wr_req_i;
        rd_req_s  <= rd_req_i;
        wr_addr_s <= wr_addr_i;
        rd_addr_s <= rd_addr_i;
        wr_data_s <= wr_data_i;
        wr_mask_s <= wr_mask_i;
      end
    end
  end else begin : g_in_comb
    assign wr_req_s  = wr_req_i;
    assign rd_req_s  = rd_req_i;
    assign wr_addr_s = wr_addr_i;
    assign rd_addr_s = rd_addr_i;
    assign wr_data_s = wr_data_i;
    assign wr_mask_s = wr_mask_i;
  end

  logic [CheckW-1:0] wr_check, chk_mask;
  logic [Width-1:0]  data_mask;

  prot_ram_enc #(.Width(Width), .EccOn(EccOn), .ParOn(ParOn)) u_enc (
    .data_i (wr_data_s),
    .check_o(wr_check)
  );

  if (EccOn) begin : g_mask_ecc
    logic unused_mask;
    assign unused_mask = ^wr_mask_s;
    assign data_mask = '1;
    assign chk_mask  = '1;
  end else if (ParOn) begin : g_mask_par
    logic unused_mask;
    assign unused_mask = ^wr_mask_s;
    for (genvar b = 0; b < CheckW; b++) begin : g_byte
      assign chk_mask[b]         = wr_mask_s[8*b];
      assign data_mask[8*b +: 8] = {8{wr_mask_s[8*b]}};
    end
  end else begin : g_mask_bit
    assign data_mask = wr_mask_s;
    assign chk_mask  = '1;
  end

  logic [StoreW-1:0] rd_word;

  prot_ram_array #(.Depth(Depth), .StoreW(StoreW)) u_array (
    .clk_i  (clk_i),
    .we_i   (wr_req_s),
    .waddr_i(wr_addr_s),
    .wdata_i({wr_check, wr_data_s}),
    .wmask_i({chk_mask, data_mask}),
    .re_i   (rd_req_s),
    .raddr_i(rd_addr_s),
    .rdata_o(rd_word)
  );

  logic rd_vld_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_vld_q <= 1'b0;
    else         rd_vld_q <= rd_req_s;
  end

  logic [Width-1:0] dec_data;
  logic [1:0]       dec_err_raw, dec_err;

  prot_ram_dec #(.Width(Width), .EccOn(EccOn), .ParOn(ParOn)) u_dec (
    .data_i (rd_word[Width-1:0]),
    .check_i(rd_word[StoreW-1:Width]),
    .data_o (dec_data),
    .err_o  (dec_err_raw)
  );

  // stale array output must not raise a status
  assign dec_err = rd_vld_q ? dec_err_raw : 2'b00;

  if (EnableOutReg) begin : g_out_reg
    logic [Width-1:0] data_q;
    logic [1:0]       err_q;
    logic             vld_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= 1'b0;
        err_q <= 2'b00;
      end else begin
        vld_q <= rd_vld_q;
        err_q <= dec_err;
      end
    end
    always_ff @(posedge clk_i) data_q <= dec_data;
    assign rd_valid_o = vld_q;
    assign rd_err_o   = err_q;
    assign rd_data_o  = data_q;
  end else begin : g_out_comb
    assign rd_valid_o = rd_vld_q;
    assign rd_err_o   = dec_err;
    assign rd_data_o  = dec_data;
  end

  // ---------------------------------------------------------------- checks
  assert_read_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i |-> ##Lat rd_valid_o);

  assert_err_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_o |-> rd_err_o == 2'b00);

  assert_err_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rd_err_o));

  if (EccOn) begin : g_chk_ecc
    assert_ecc_full_mask_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_req_i |-> (&wr_mask_i));
  end

  if (ParOn) begin : g_chk_par
    for (genvar b = 0; b < CheckW; b++) begin : g_byte
      assert_par_byte_mask_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_req_i |-> (wr_mask_i[8*b +: 8] == 8'h00 || wr_mask_i[8*b +: 8] == 8'hff));
    end
  end

endmodule

// File: tb/prot_sdp_ram_tb_top.sv
`timescale 1ns/1ps

module prot_sdp_ram_harness #(
  parameter int W      = 32,
  parameter bit Ecc    = 1'b0,
  parameter bit Par    = 1'b0,
  parameter bit InReg  = 1'b0,
  parameter bit OutReg = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  output logic done,
  output int   n_chk,
  output int   n_fail
);

  localparam int Depth = 16;
  localparam int AW    = 4;
  localparam int NB    = W / 8;
  localparam int Lat   = 1 + int'(InReg) + int'(OutReg);

  logic          wr_req, rd_req;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [W-1:0]  wr_data, wr_mask;
  logic [W-1:0]  rd_data;
  logic          rd_valid;
  logic [1:0]    rd_err;

  prot_sdp_ram #(
    .Depth(Depth), .Width(W), .EnableEcc(Ecc), .EnableParity(Par),
    .EnableInReg(InReg), .EnableOutReg(OutReg)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_req_i(wr_req), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .wr_mask_i(wr_mask),
    .rd_req_i(rd_req), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .rd_err_o(rd_err)
  );

  // reference model
  logic [W-1:0] mem_m [Depth];
  logic [W-1:0] fx_m  [Depth];
  bit           ev  [8];
  bit           edc [8];
  logic [W-1:0] ed  [8];
  logic [1:0]   ee  [8];
  string        dtag[8];
  string        etag[8];
  int           cyc;

  task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s (W=%0d ecc=%0d par=%0d): actual %h expected %h",
               tag, what, W, Ecc, Par, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rnd_word();
    logic [63:0] r;
    r = {$urandom(), $urandom()};
    return r[W-1:0];
  endfunction

  function automatic logic [W-1:0] rnd_mask();
    logic [W-1:0] m;
    logic [31:0]  r;
    r = $urandom();
    if (Ecc) m = '1;
    else if (Par) for (int b = 0; b < NB; b++) m[8*b +: 8] = {8{r[b]}};
    else m = rnd_word();
    return m;
  endfunction

  task automatic step(bit wr, int wa, logic [W-1:0] wd, logic [W-1:0] wm,
                      bit rd, int ra, string tag);
    int s, t, n;
    bit odd;
    logic [W-1:0] raw;
    @(negedge clk);
    s = cyc % 8;
    check(rd_valid == ev[s], "R1", "valid", 64'(rd_valid), 64'(ev[s]));
    if (ev[s] && rd_valid) begin
      check(rd_err == ee[s], etag[s], "err", 64'(rd_err), 64'(ee[s]));
      if (edc[s]) check(rd_data == ed[s], dtag[s], "data", 64'(rd_data), 64'(ed[s]));
    end
    if (!ev[s]) check(rd_err == 2'b00, "R7", "idle err", 64'(rd_err), 64'd0);
    ev[s] = 1'b0;
    wr_req  = wr;
    wr_addr = AW'(wa);
    wr_data = wd;
    wr_mask = wm;
    rd_req  = rd;
    rd_addr = AW'(ra);
    if (rd) begin
      t = (cyc + Lat) % 8;
      ev[t] = 1'b1;
      edc[t] = 1'b1;
      dtag[t] = tag;
      raw = mem_m[ra] ^ fx_m[ra];
      if (Ecc) begin
        n = $countones(fx_m[ra]);
        ed[t] = mem_m[ra];
        ee[t] = (n == 0) ? 2'b00 : (n == 1) ? 2'b01 : 2'b10;
        edc[t] = (n < 2);
      end else if (Par) begin
        odd = 1'b0;
        for (int b = 0; b < NB; b++) odd |= ^fx_m[ra][8*b +: 8];
        ed[t] = raw;
        ee[t] = odd ? 2'b10 : 2'b00;
      end else begin
        ed[t] = mem_m[ra];
        ee[t] = 2'b00;
      end
      etag[t] = (ee[t] == 2'b00) ? "R7" : tag;
    end
    if (wr) begin
      mem_m[wa] = (mem_m[wa] & ~wm) | (wd & wm);
      fx_m[wa]  = fx_m[wa] & ~wm;
    end
    cyc++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, '0, '0, 1'b0, 0, "R1");
  endtask

  // zero-time bit flip inside the storage array, pipeline idle
  task automatic inject(int a, logic [W-1:0] m);
    logic [W-1:0] cur;
    cur = dut_i.u_array.mem_q[a][W-1:0];
    dut_i.u_array.mem_q[a][W-1:0] = cur ^ m;
    fx_m[a] = fx_m[a] ^ m;
  endtask

  initial begin
    done = 1'b0; n_chk = 0; n_fail = 0; cyc = 0;
    wr_req = 1'b0; rd_req = 1'b0; wr_addr = '0; rd_addr = '0;
    wr_data = '0; wr_mask = '0;
    for (int i = 0; i < 8; i++) ev[i] = 1'b0;
    for (int i = 0; i < Depth; i++) begin mem_m[i] = '0; fx_m[i] = '0; end

    // R8: outputs quiet in reset
    repeat (2) @(negedge clk);
    check(rd_valid == 1'b0, "R8", "reset valid", 64'(rd_valid), 64'd0);
    check(rd_err == 2'b00, "R8", "reset err", 64'(rd_err), 64'd0);
    @(posedge rst_n);

    // fill, then back-to-back readback
    for (int a = 0; a < Depth; a++) step(1'b1, a, rnd_word(), '1, 1'b0, 0, "R2");
    for (int a = 0; a < Depth; a++) step(1'b0, 0, '0, '0, 1'b1, a, "R2");
    idle(Lat + 1);

    // explicit collision, R3
    step(1'b1, 5, rnd_word(), '1, 1'b1, 5, "R3");
    step(1'b0, 0, '0, '0, 1'b1, 5, "R2");
    idle(Lat + 1);

    // random traffic, masked per mode (R2, R9), forced collisions (R3)
    for (int i = 0; i < 400; i++) begin
      int wa, ra;
      bit wr, rd;
      wa = int'($urandom_range(Depth - 1));
      ra = int'($urandom_range(Depth - 1));
      wr = 1'($urandom());
      rd = 1'($urandom());
      if (i % 7 == 0) begin ra = wa; wr = 1'b1; rd = 1'b1; end
      step(wr, wa, rnd_word(), rnd_mask(), rd, ra,
           (wr && rd && wa == ra) ? "R3" : ((Ecc || Par) ? "R9" : "R2"));
    end
    idle(Lat + 1);

    if (Ecc) begin
      inject(3, W'(1) << 5);
      step(1'b0, 0, '0, '0, 1'b1, 3, "R4");
      idle(Lat + 1);
      inject(3, W'(1) << 17);
      step(1'b0, 0, '0, '0, 1'b1, 3, "R5");
      idle(Lat + 1);
      step(1'b1, 3, rnd_word(), '1, 1'b0, 0, "R10");
      idle(Lat + 1);
      step(1'b0, 0, '0, '0, 1'b1, 3, "R10");
      idle(Lat + 1);
      inject(9, W'(1) << (W - 1));
      step(1'b0, 0, '0, '0, 1'b1, 9, "R4");
      step(1'b0, 0, '0, '0, 1'b1, 9, "R4");
      idle(Lat + 1);
      inject(9, W'(1));
      step(1'b0, 0, '0, '0, 1'b1, 9, "R5");
      idle(Lat + 1);
    end

    if (Par) begin
      inject(3, W'(1) << 5);
      step(1'b0, 0, '0, '0, 1'b1, 3, "R6");
      idle(Lat + 1);
      inject(3, W'(1) << 12);
      step(1'b0, 0, '0, '0, 1'b1, 3, "R6");
      idle(Lat + 1);
      // rewrite byte 0 only: byte 1 still bad
      step(1'b1, 3, rnd_word(), W'(8'hff), 1'b0, 0, "R10");
      idle(Lat + 1);
      step(1'b0, 0, '0, '0, 1'b1, 3, "R6");
      idle(Lat + 1);
      step(1'b1, 3, rnd_word(), W'(16'hff00), 1'b0, 0, "R10");
      idle(Lat + 1);
      step(1'b0, 0, '0, '0, 1'b1, 3, "R10");
      idle(Lat + 1);
    end

    idle(Lat + 2);
    done = 1'b1;
  end

endmodule

module prot_sdp_ram_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic d0, d1, d2, d3;
  int   c0, c1, c2, c3, f0, f1, f2, f3;
  bit   wd_hit = 1'b0;

  prot_sdp_ram_harness #(.W(32), .Ecc(1'b1), .InReg(1'b1), .OutReg(1'b1)) h_ecc32 (
    .clk(clk), .rst_n(rst_n), .done(d0), .n_chk(c0), .n_fail(f0));
  prot_sdp_ram_harness #(.W(64), .Ecc(1'b1), .InReg(1'b1)) h_ecc64 (
    .clk(clk), .rst_n(rst_n), .done(d1), .n_chk(c1), .n_fail(f1));
  prot_sdp_ram_harness #(.W(32), .Par(1'b1)) h_par (
    .clk(clk), .rst_n(rst_n), .done(d2), .n_chk(c2), .n_fail(f2));
  prot_sdp_ram_harness #(.W(32), .OutReg(1'b1)) h_raw (
    .clk(clk), .rst_n(rst_n), .done(d3), .n_chk(c3), .n_fail(f3));

  initial begin
    int total, failed;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    fork
      wait (d0 && d1 && d2 && d3);
      begin
        repeat (100000) @(posedge clk);
        wd_hit = 1'b1;
      end
    join_any
    total  = c0 + c1 + c2 + c3;
    failed = f0 + f1 + f2 + f3;
    if (wd_hit) begin
      total++;
      failed++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule